// File: doc/BRIEF.md
# Serial EEPROM Burst Read Engine

The block reads a run of bytes from a serial EEPROM over a bit-level bus. The bus has a serial clock, a data line toward the memory, a data line from the memory, and a pair of access lines. Selection uses the access pair instead of a single chip select: the memory is selected when the high access line is 1 and the low access line is 0. The pair is always moved one line at a time, so the bus never passes through the state where both lines are 0. A host pulses `start_i` with a byte offset and a byte count. The engine then selects the memory and sends the read command 0x03 and two address bytes. It clocks in the requested bytes and deselects the memory.

Each received byte leaves the block on a valid/ready stream. `rd_valid_o` stays high and `rd_data_o` holds its value until `rd_ready_i` is seen high on a clock edge. While a byte waits, the engine parks the bus with the serial clock low and starts no further bit. With `rd_ready_i` held high, each byte is valid for exactly one cycle. Every change of a bus line is held for `DIV` system clock cycles. `done_o` pulses once, after the deselect sequence has finished.

Top module: `eeprom_burst_reader`

## Requirements
- R1: After reset, `ee_sck_o` is 0, `ee_acc_hi_o` is 0, `ee_acc_lo_o` is 1, `busy_o` is 0 and `rd_valid_o` is 0.
- R2: Selection first drives `ee_acc_hi_o` from 0 to 1 while `ee_acc_lo_o` stays 1. In a later step it drives `ee_acc_lo_o` from 1 to 0. The two access lines never change in the same cycle.
- R3: Every accepted request ends with deselection. First `ee_acc_lo_o` is driven to 1. In a later step `ee_acc_hi_o` is driven to 0. `done_o` is high for exactly one cycle, the cycle in which `ee_acc_hi_o` falls, and only once per request.
- R4: While the memory is selected, the engine shifts out 24 bits: the command byte 0x03, then offset bits 15..8, then offset bits 7..0. It then shifts in exactly count bytes. The first of these comes from the offset, and the following ones come from the next addresses, wrapping at 16 bits.
- R5: Bytes leave most significant bit first. For each bit, `ee_mosi_o` is set while `ee_sck_o` is low, then `ee_sck_o` rises, then it falls. `ee_mosi_o` never changes while `ee_sck_o` is high.
- R6: Incoming bytes are most significant bit first. Each bit is taken from `ee_miso_i` while `ee_sck_o` is high, after the rise and before the fall. It is shifted in at the least significant end.
- R7: A start whose offset is above 0xFFFF is rejected. `err_o` pulses for one cycle, no bus line changes, and `done_o` is not raised. An offset of exactly 0xFFFF is accepted.
- R8: Any two changes of the bus outputs (`ee_sck_o`, `ee_mosi_o`, `ee_acc_hi_o`, `ee_acc_lo_o`) are at least `DIV` system clock cycles apart.
- R9: `start_i` is ignored while `busy_o` is high. The request in progress keeps its offset and count.
- R10: `rd_valid_o` and `rd_data_o` hold steady while `rd_valid_o` is high and `rd_ready_i` is low. Each handshake delivers one byte. No serial clock pulse happens while a byte waits.
- R11: A count of zero still runs selection, the command and address bytes, and deselection. It delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| offset_i | input | OFFS_W | Byte offset of the first byte; values above 0xFFFF are rejected |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| rd_valid_o | output | 1 | Received byte available |
| rd_data_o | output | 8 | Received byte |
| rd_ready_i | input | 1 | Consumer accepts the byte |
| ee_sck_o | output | 1 | Serial clock to the memory |
| ee_mosi_o | output | 1 | Serial data to the memory |
| ee_miso_i | input | 1 | Serial data from the memory |
| ee_acc_hi_o | output | 1 | High access line |
| ee_acc_lo_o | output | 1 | Low access line |

## Verification
The case that is hardest to reach from the ports is a consumer that stalls on the last byte, or on a byte in the middle. In that case deselection or the next byte must wait, and the hold spacing on the bus must still be kept. Random ready patterns cover this, including a mode in which ready is seldom high. Directed runs cover an offset of 0xFFFF that wraps to address 0, a count of zero, a start issued while busy, and offsets just above the limit. A bench model of the memory decodes the command and address from the bus and answers from an address-derived pattern.

// File: rtl/eebr_pkg.sv
package eebr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;

  typedef enum logic { DIR_OUT = 1'b0, DIR_IN = 1'b1 } dir_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EN_HI, ST_EN_LO, ST_CMD, ST_ADH, ST_ADL,
    ST_RD, ST_HOLD, ST_DIS_LO, ST_DIS_HI
  } state_t;
endpackage

// File: rtl/eebr_pacer.sv
module eebr_pacer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt_q;
  logic at_end;

  assign at_end = (cnt_q == CW'(DIV - 1));
  assign tick_o = run_i && !clr_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr_i || !run_i || at_end) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R8: ticks never arrive back to back unless DIV is 1
  generate
    if (DIV > 1) begin : g_gap
      assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/eebr_shifter.sv
module eebr_shifter import eebr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              go_i,
  input  dir_t              dir_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam int BCW = $clog2(BYTE_W);

  logic              act_q;
  dir_t              dir_q;
  logic [BCW-1:0]    bit_q;
  logic [1:0]        ph_q;
  logic [BYTE_W-1:0] sr_q;
  logic              sck_q, mosi_q;
  logic              step;

  assign step   = act_q && tick_i;
  assign done_o = step && (ph_q == 2'd2) && (bit_q == BCW'(BYTE_W - 1));
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign byte_o = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= DIR_OUT;
      bit_q  <= '0;
      ph_q   <= '0;
      sr_q   <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else if (go_i) begin
      act_q <= 1'b1;
      dir_q <= dir_i;
      bit_q <= '0;
      ph_q  <= '0;
      sr_q  <= byte_i;
      sck_q <= 1'b0;
    end else if (step) begin
      unique case (ph_q)
        2'd0: begin
          if (dir_q == DIR_OUT) mosi_q <= sr_q[BYTE_W-1];
          else                  sck_q  <= 1'b1;
          ph_q <= 2'd1;
        end
        2'd1: begin
          if (dir_q == DIR_OUT) sck_q <= 1'b1;
          else                  sr_q  <= {sr_q[BYTE_W-2:0], miso_i};
          ph_q <= 2'd2;
        end
        default: begin
          sck_q <= 1'b0;
          ph_q  <= 2'd0;
          bit_q <= bit_q + 1'b1;
          if (dir_q == DIR_OUT) sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
          if (bit_q == BCW'(BYTE_W - 1)) act_q <= 1'b0;
        end
      endcase
    end
  end

  assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(mosi_q));
  assert_sample_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir_q == DIR_IN && ph_q == 2'd1) |-> sck_q);
  assert_clock_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sck_q);
endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader import eebr_pkg::*; #(
  parameter int DIV    = 4,
  parameter int OFFS_W = 20,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              rd_ready_i,
  output logic              ee_sck_o,
  output logic              ee_mosi_o,
  input  logic              ee_miso_i,
  output logic              ee_acc_hi_o,
  output logic              ee_acc_lo_o
);
  localparam int SW = $clog2(DIV + 1);

  state_t            st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              hi_q, lo_q, done_q, err_q, vld_q;
  logic [BYTE_W-1:0] dat_q;
  logic              tick, over, idle, take, reject;
  logic              sh_go, sh_done;
  dir_t              sh_dir;
  logic [BYTE_W-1:0] sh_byte, sh_rx;

  generate
    if (OFFS_W > ADDR_W) begin : g_wide
      assign over = |offset_i[OFFS_W-1:ADDR_W];
    end else begin : g_narrow
      assign over = 1'b0;
    end
  endgenerate

  assign idle   = (st_q == ST_IDLE);
  assign take   = start_i && idle && !over;
  assign reject = start_i && idle && over;

  eebr_pacer #(.DIV(DIV)) u_pacer (
    .clk(clk), .rst_n(rst_n), .clr_i(take), .run_i(!idle), .tick_o(tick)
  );

  eebr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .go_i(sh_go), .dir_i(sh_dir),
    .byte_i(sh_byte), .miso_i(ee_miso_i), .sck_o(ee_sck_o), .mosi_o(ee_mosi_o),
    .byte_o(sh_rx), .done_o(sh_done)
  );

  always_comb begin
    sh_go   = 1'b0;
    sh_dir  = DIR_OUT;
    sh_byte = CMD_READ;
    unique case (st_q)
      ST_EN_LO: sh_go = tick;
      ST_CMD: begin
        sh_go   = sh_done;
        sh_byte = addr_q[ADDR_W-1 -: BYTE_W];
      end
      ST_ADH: begin
        sh_go   = sh_done;
        sh_byte = addr_q[BYTE_W-1:0];
      end
      ST_ADL: begin
        sh_go  = sh_done && (left_q != '0);
        sh_dir = DIR_IN;
      end
      ST_HOLD: begin
        sh_go  = tick && !vld_q && (left_q != '0);
        sh_dir = DIR_IN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      left_q <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      if (vld_q && rd_ready_i) vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (take) begin
          addr_q <= offset_i[ADDR_W-1:0];
          left_q <= count_i;
          st_q   <= ST_EN_HI;
        end
        ST_EN_HI: if (tick) begin
          hi_q <= 1'b1;
          st_q <= ST_EN_LO;
        end
        ST_EN_LO: if (tick) begin
          lo_q <= 1'b0;
          st_q <= ST_CMD;
        end
        ST_CMD: if (sh_done) st_q <= ST_ADH;
        ST_ADH: if (sh_done) st_q <= ST_ADL;
        ST_ADL: if (sh_done) st_q <= (left_q == '0) ? ST_DIS_LO : ST_RD;
        ST_RD: if (sh_done) begin
          dat_q  <= sh_rx;
          vld_q  <= 1'b1;
          left_q <= left_q - 1'b1;
          st_q   <= ST_HOLD;
        end
        ST_HOLD: if (tick && !vld_q) st_q <= (left_q == '0) ? ST_DIS_LO : ST_RD;
        ST_DIS_LO: if (tick) begin
          lo_q <= 1'b1;
          st_q <= ST_DIS_HI;
        end
        ST_DIS_HI: if (tick) begin
          hi_q   <= 1'b0;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rd_valid_o  = vld_q;
  assign rd_data_o   = dat_q;
  assign ee_acc_hi_o = hi_q;
  assign ee_acc_lo_o = lo_q;

  // spacing monitor for R8
  logic [SW-1:0] since_q;
  logic          pv_sck, pv_mosi, pv_hi, pv_lo, chg;
  assign chg = (ee_sck_o != pv_sck) || (ee_mosi_o != pv_mosi) ||
               (hi_q != pv_hi) || (lo_q != pv_lo);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SW'(DIV);
      pv_sck  <= 1'b0;
      pv_mosi <= 1'b0;
      pv_hi   <= 1'b0;
      pv_lo   <= 1'b1;
    end else begin
      pv_sck  <= ee_sck_o;
      pv_mosi <= ee_mosi_o;
      pv_hi   <= hi_q;
      pv_lo   <= lo_q;
      if (chg) since_q <= '0;
      else if (since_q < SW'(DIV)) since_q <= since_q + 1'b1;
    end
  end

  assert_bus_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (since_q >= SW'(DIV - 1)));
  assert_enable_hi_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> lo_q);
  assert_enable_lo_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lo_q) |-> (hi_q && $past(hi_q)));
  assert_disable_lo_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> hi_q);
  assert_disable_hi_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_q) |-> (lo_q && $past(lo_q) && done_q));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_sck_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sck_o |-> (hi_q && !lo_q));
  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy_o && !hi_q && lo_q));
  assert_hold_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rd_ready_i) |=> (vld_q && $stable(dat_q)));
  assert_park_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !ee_sck_o);
endmodule

// File: tb/eeprom_burst_reader_bench.sv
`timescale 1ns/1ps
module eeprom_burst_reader_bench;
  localparam int DIV = 4;
  localparam int OFFS_W = 20;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [OFFS_W-1:0] offset = '0;
  logic [CNT_W-1:0] count = '0;
  logic busy, done, err, vld, rdy, sck, mosi, miso, ahi, alo;
  logic [7:0] data;

  always #2.5 clk = ~clk;

  eeprom_burst_reader #(.DIV(DIV), .OFFS_W(OFFS_W), .CNT_W(CNT_W)) u_eeprom_burst_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .offset_i(offset), .count_i(count),
    .busy_o(busy), .done_o(done), .err_o(err), .rd_valid_o(vld), .rd_data_o(data),
    .rd_ready_i(rdy), .ee_sck_o(sck), .ee_mosi_o(mosi), .ee_miso_i(miso),
    .ee_acc_hi_o(ahi), .ee_acc_lo_o(alo)
  );

  int n_cmp = 0, n_bad = 0;
  int rdy_mode = 0;
  bit summary_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
  endfunction

  // monitor and memory model
  bit mon_clr = 0;
  logic p_sck = 0, p_mosi = 0, p_hi = 0, p_lo = 1, p_vld = 0, p_rdy = 0;
  logic [7:0] p_data = 0;
  int cyc = 0, last_chg = -1, min_gap = 1000000;
  int viol_acc = 0, viol_mosi = 0, viol_sck = 0, viol_hs = 0;
  int bus_chg = 0, done_cnt = 0, err_cnt = 0, got_n = 0;
  logic [7:0] got [0:63];
  int bitn = 0, k, b;
  logic [23:0] shreg = 0;
  logic [7:0] m_cmd = 8'hEE, tmp;
  logic [15:0] m_addr = 0;

  always @(posedge clk) begin
    cyc++;
    if (mon_clr) begin
      last_chg = -1; min_gap = 1000000; viol_acc = 0; viol_mosi = 0; viol_sck = 0;
      viol_hs = 0; bus_chg = 0; done_cnt = 0; err_cnt = 0; got_n = 0;
      m_cmd = 8'hEE; m_addr = 0;
    end else if (rst_n) begin
      if (sck != p_sck || mosi != p_mosi || ahi != p_hi || alo != p_lo) begin
        bus_chg++;
        if (last_chg >= 0 && cyc - last_chg < min_gap) min_gap = cyc - last_chg;
        last_chg = cyc;
      end
      if ((ahi != p_hi && alo != p_lo) || (!ahi && !alo)) viol_acc++;
      if (sck && p_sck && mosi != p_mosi) viol_mosi++;
      if (sck && !(ahi && !alo)) viol_sck++;
      if (p_vld && !p_rdy && (!vld || data != p_data)) viol_hs++;
      if (vld && sck) viol_hs++;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (vld && rdy && got_n < 64) begin got[got_n] = data; got_n++; end
      if (!(ahi && !alo)) begin
        bitn = 0; miso <= 1'b0;
      end else begin
        if (sck && !p_sck) begin
          if (bitn < 24) shreg = {shreg[22:0], mosi};
          bitn++;
        end
        if (!sck && p_sck && bitn >= 24) begin
          if (bitn == 24) begin m_cmd = shreg[23:16]; m_addr = shreg[15:0]; end
          k = (bitn - 24) / 8;
          b = 7 - ((bitn - 24) % 8);
          tmp = mem_byte(16'(m_addr + k));
          miso <= tmp[b];
        end
      end
    end
    p_sck = sck; p_mosi = mosi; p_hi = ahi; p_lo = alo;
    p_vld = vld; p_rdy = rdy; p_data = data;
  end

  initial begin
    miso = 1'b0;
    rdy = 1'b1;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: rdy = 1'b1;
        1: rdy = ($urandom % 3) != 0;
        default: rdy = ($urandom % 16) == 0;
      endcase
    end
  end

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0;
  endtask

  task automatic run_txn(input int ofs, input int cnt, input int mode, input bit poke);
    int t;
    clear_mon();
    rdy_mode = mode;
    @(negedge clk);
    start = 1; offset = OFFS_W'(ofs); count = CNT_W'(cnt);
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (150) @(negedge clk);
      start = 1; offset = OFFS_W'(ofs ^ 16'h1111); count = 2;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 30000) begin @(negedge clk); t++; end
    repeat (3 * DIV) @(negedge clk);
    chk(done_cnt == 1, "R3 done pulses", done_cnt, 1);
    chk(viol_acc == 0, "R2 R3 access order", viol_acc, 0);
    chk(ahi == 0 && alo == 1, "R3 deselected at end", {ahi, alo}, 1);
    chk(m_cmd == 8'h03, "R4 command byte", m_cmd, 3);
    chk(m_addr == 16'(ofs), poke ? "R9 address kept" : "R4 address", m_addr, ofs & 16'hFFFF);
    chk(got_n == cnt, cnt == 0 ? "R11 no bytes" : "R10 byte count", got_n, cnt);
    for (int i = 0; i < cnt && i < got_n; i++)
      chk(got[i] == mem_byte(16'(ofs + i)), "R6 byte value", got[i], mem_byte(16'(ofs + i)));
    chk(viol_mosi == 0 && viol_sck == 0, "R5 bit timing", viol_mosi + viol_sck, 0);
    chk(min_gap >= DIV, "R8 line spacing", min_gap, DIV);
    chk(viol_hs == 0, "R10 stream hold", viol_hs, 0);
    chk(err_cnt == 0, "R7 no error", err_cnt, 0);
  endtask

  task automatic reject(input int ofs);
    clear_mon();
    @(negedge clk);
    start = 1; offset = OFFS_W'(ofs); count = 3;
    @(negedge clk);
    start = 0;
    repeat (10 * DIV) @(negedge clk);
    chk(err_cnt == 1, "R7 error pulse", err_cnt, 1);
    chk(bus_chg == 0, "R7 no bus activity", bus_chg, 0);
    chk(done_cnt == 0 && !busy, "R7 no done", done_cnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sck == 0 && ahi == 0 && alo == 1 && !busy && !vld, "R1 reset state",
        {sck, ahi, alo, busy, vld}, 5'b00100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sck == 0 && ahi == 0 && alo == 1 && !busy && !vld, "R1 idle after reset",
        {sck, ahi, alo, busy, vld}, 5'b00100);
    run_txn(16'h1234, 0, 0, 0);          // R11
    run_txn(16'hFFFF, 2, 0, 0);          // R4 wrap, R7 boundary accepted
    run_txn(16'h0000, 3, 2, 0);          // R10 heavy stall
    run_txn(16'h8001, 3, 1, 1);          // R9 start while busy
    reject(20'h10000);                   // R7
    reject(20'hFFFFF);                   // R7
    for (int n = 0; n < 10; n++)
      run_txn(int'($urandom % 65536), int'($urandom % 5), int'($urandom % 3), 0);
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule